// File: doc/BRIEF.md
# Packed Dual-MAC Dot Product Engine

This block forms the dot product of a coefficient vector and a data vector of signed 16-bit elements. Both vectors are streamed in as 32-bit words. Each word packs two neighbouring elements: element n sits in the low half and element n+1 in the high half. Two signed 16x16 multipliers work on the two halves of every accepted word pair in the same cycle, so each accepted beat performs two multiply-accumulates. Low-half products feed an even accumulator and high-half products feed an odd accumulator. After the programmed number of word pairs, the two partial sums are added and presented as the result.

A run begins with a one-cycle start pulse. The pulse carries the number of word pairs and the accumulation mode. In the default mode each accumulator wraps in 32-bit two's complement. In the extended mode each accumulator is 40 bits wide and saturates at the signed 40-bit limits instead of wrapping. Products are registered, so the accumulate stage runs one cycle behind the multiply. When the last pair has been taken, the input is held off while the pipeline drains and the two sums are combined. A one-cycle done strobe then marks the new result. The block does not fetch from memory: it only consumes the word stream handed to it.

Top module: `pairdot_engine`

## Requirements
- R1: After reset, inReady and done are 0 and resultWide is 0.
- R2: For each accepted word pair, the signed product of the low halves (bits 15:0) of coefWord and dataWord is added to the even sum. The signed product of the high halves (bits 31:16) is added to the odd sum. The final result is the even sum plus the odd sum. Cycles with inValid low do not change the result.
- R3: With extMode = 0 latched at start, each accumulator and the final addition wrap in 32-bit two's complement. resultWide is the 32-bit result sign-extended to 40 bits.
- R4: With extMode = 1 latched at start, each accumulate step and the final addition saturate to the signed 40-bit range, from -2^39 to 2^39-1.
- R5: resultHalf equals bits 15:0 of resultWide. Both outputs hold their value until the next done strobe.
- R6: Both accumulators are cleared at every accepted start, so a run's result does not depend on earlier runs.
- R7: Exactly pairCount word pairs are accepted per run, with one accepted when inValid and inReady are both 1 at a clock edge. inReady is 0 from the edge of the last accepted pair until after done. A pairCount of 0 accepts nothing and gives a result of 0.
- R8: done is high for exactly one cycle, starting at the second clock edge after the edge that accepted the last pair. When pairCount is 0, it starts at the second edge after the start edge.
- R9: A start pulse is taken only when no run is in progress. A pulse during a run changes neither that run's count, its mode nor its result. pairCount and extMode are sampled only with an accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begins a run when the engine is idle |
| pairCount | input | 16 | Number of word pairs in the run, sampled with start |
| extMode | input | 1 | 1 selects 40-bit saturating accumulation, sampled with start |
| coefWord | input | 32 | Two packed signed coefficients, element n in the low half |
| dataWord | input | 32 | Two packed signed data samples, element n in the low half |
| inValid | input | 1 | coefWord and dataWord carry a pair |
| inReady | output | 1 | Engine accepts a pair at this edge |
| done | output | 1 | One-cycle strobe marking a new result |
| resultHalf | output | 16 | Low halfword of the result |
| resultWide | output | 40 | Full result, sign-extended in wrap mode |

## Verification
The dot product is tried with small hand-picked words, where any swap of the lanes or of the sign handling gives a different sum. Random packed words with random valid gaps show that stalls neither drop nor repeat a pair. Long runs of the most negative value squared, and of negative products, reach past 2^39. There the saturating result is told apart from the wrapped one, and saturation at each step from a single clamp at the end. A zero-length run, a start pulse injected mid-run, and back-to-back runs pin down the handshake, the done timing and the clearing of the sums.

// File: rtl/pairdot_pkg.sv
package pairdot_pkg;

  typedef struct packed {
    logic clearAll;
    logic capture;
    logic addProd;
    logic combine;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_COMB
  } ctrlState_t;

endpackage

// File: rtl/pairdot_ctrl.sv
module pairdot_ctrl
  import pairdot_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] pairCount,
  input  logic             extMode,
  input  logic             inValid,
  output logic             inReady,
  output logic             done,
  output logic             satMode,
  output dpStrobe_t        strobe
);

  ctrlState_t       state;
  logic [CNT_W-1:0] pairsLeft;
  logic             addQ;
  logic             doneQ;
  logic             modeQ;
  logic             startTake;
  logic             beatTake;

  assign startTake = (state == ST_IDLE) && startPulse;
  assign beatTake  = (state == ST_RUN) && inValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      pairsLeft <= '0;
      addQ      <= 1'b0;
      doneQ     <= 1'b0;
      modeQ     <= 1'b0;
    end else begin
      addQ  <= beatTake;
      doneQ <= (state == ST_COMB);
      case (state)
        ST_IDLE: begin
          if (startPulse) begin
            modeQ     <= extMode;
            pairsLeft <= pairCount;
            state     <= (pairCount == '0) ? ST_DRAIN : ST_RUN;
          end
        end
        ST_RUN: begin
          if (inValid) begin
            pairsLeft <= pairsLeft - 1'b1;
            if (pairsLeft == CNT_W'(1)) state <= ST_DRAIN;
          end
        end
        ST_DRAIN: state <= ST_COMB;
        ST_COMB:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign inReady         = (state == ST_RUN);
  assign done            = doneQ;
  assign satMode         = modeQ;
  assign strobe.clearAll = startTake;
  assign strobe.capture  = beatTake;
  assign strobe.addProd  = addQ;
  assign strobe.combine  = (state == ST_COMB);

endmodule

// File: rtl/pairdot_dp.sv
module pairdot_dp
  import pairdot_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobe_t           strobe,
  input  logic                satMode,
  input  logic [2*HALF_W-1:0] coefWord,
  input  logic [2*HALF_W-1:0] dataWord,
  output logic [ACC_W-1:0]    resultWide
);

  localparam int PROD_W  = 2 * HALF_W;
  localparam int LANES   = 2;
  localparam int EXT_PAD = ACC_W - PROD_W;
  localparam logic [ACC_W:0] SAT_HI = {2'b00, {(ACC_W-1){1'b1}}};
  localparam logic [ACC_W:0] SAT_LO = {2'b11, {(ACC_W-1){1'b0}}};

  function automatic logic [ACC_W-1:0] widen(input logic [PROD_W-1:0] v);
    return {{EXT_PAD{v[PROD_W-1]}}, v};
  endfunction

  function automatic logic [ACC_W-1:0] clampSum(input logic [ACC_W-1:0] a,
                                                input logic [ACC_W-1:0] b);
    logic [ACC_W:0] s;
    s = {a[ACC_W-1], a} + {b[ACC_W-1], b};
    if ($signed(s) > $signed(SAT_HI))      return SAT_HI[ACC_W-1:0];
    else if ($signed(s) < $signed(SAT_LO)) return SAT_LO[ACC_W-1:0];
    else                                   return s[ACC_W-1:0];
  endfunction

  function automatic logic [ACC_W-1:0] wrapSum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b);
    logic [PROD_W-1:0] s;
    s = a[PROD_W-1:0] + b[PROD_W-1:0];
    return widen(s);
  endfunction

  function automatic logic [ACC_W-1:0] stepSum(input logic [ACC_W-1:0] a,
                                               input logic [ACC_W-1:0] b,
                                               input logic sat);
    return sat ? clampSum(a, b) : wrapSum(a, b);
  endfunction

  genvar lane;
  generate
    for (lane = 0; lane < LANES; lane++) begin : gLane
      logic signed [HALF_W-1:0] coefH;
      logic signed [HALF_W-1:0] dataH;
      logic signed [PROD_W-1:0] prodNext;
      logic        [PROD_W-1:0] prodQ;
      logic        [ACC_W-1:0]  accQ;

      assign coefH    = coefWord[lane*HALF_W +: HALF_W];
      assign dataH    = dataWord[lane*HALF_W +: HALF_W];
      assign prodNext = coefH * dataH;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          prodQ <= '0;
          accQ  <= '0;
        end else begin
          if (strobe.capture) prodQ <= prodNext;
          if (strobe.clearAll)     accQ <= '0;
          else if (strobe.addProd) accQ <= stepSum(accQ, widen(prodQ), satMode);
        end
      end
    end
  endgenerate

  logic [ACC_W-1:0] resultQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultQ <= '0;
    else if (strobe.combine)
      resultQ <= stepSum(gLane[0].accQ, gLane[1].accQ, satMode);
  end

  assign resultWide = resultQ;

endmodule

// File: rtl/pairdot_engine.sv
module pairdot_engine
  import pairdot_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 40
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startPulse,
  input  logic [CNT_W-1:0]    pairCount,
  input  logic                extMode,
  input  logic [2*HALF_W-1:0] coefWord,
  input  logic [2*HALF_W-1:0] dataWord,
  input  logic                inValid,
  output logic                inReady,
  output logic                done,
  output logic [HALF_W-1:0]   resultHalf,
  output logic [ACC_W-1:0]    resultWide
);

  dpStrobe_t strobeBus;
  logic      satMode;

  pairdot_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .pairCount  (pairCount),
    .extMode    (extMode),
    .inValid    (inValid),
    .inReady    (inReady),
    .done       (done),
    .satMode    (satMode),
    .strobe     (strobeBus)
  );

  pairdot_dp #(.HALF_W(HALF_W), .ACC_W(ACC_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobeBus),
    .satMode    (satMode),
    .coefWord   (coefWord),
    .dataWord   (dataWord),
    .resultWide (resultWide)
  );

  assign resultHalf = resultWide[HALF_W-1:0];

endmodule

// File: rtl/pairdot_chk.sv
module pairdot_chk
  import pairdot_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 16,
  parameter int ACC_W  = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] pairCount,
  input logic             inValid,
  input logic             inReady,
  input logic             done,
  input logic             satMode,
  input dpStrobe_t        strobe,
  input logic [ACC_W-1:0] resultWide
);

  localparam int TOP_BITS = ACC_W - 2*HALF_W + 1;

  logic [CNT_W:0]      acceptCnt;
  logic [CNT_W:0]      latchedCnt;
  logic [TOP_BITS-1:0] upperBits;

  assign upperBits = resultWide[ACC_W-1:2*HALF_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acceptCnt  <= '0;
      latchedCnt <= '0;
    end else if (strobe.clearAll) begin
      acceptCnt  <= '0;
      latchedCnt <= {1'b0, pairCount};
    end else if (inValid && inReady) begin
      acceptCnt <= acceptCnt + 1'b1;
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_no_ready_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !inReady);

  assert_beat_limit_R7: assert property (@(posedge clk) disable iff (!rstN)
    acceptCnt <= latchedCnt);

  assert_result_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> $stable(resultWide));

  assert_wrap_range_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !satMode) |-> ((&upperBits) || !(|upperBits)));

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clearAll |-> !inReady);

endmodule

bind pairdot_engine pairdot_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W), .ACC_W(ACC_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .pairCount  (pairCount),
  .inValid    (inValid),
  .inReady    (inReady),
  .done       (done),
  .satMode    (satMode),
  .strobe     (strobeBus),
  .resultWide (resultWide)
);

// File: tb/tb_pairdot_engine.sv
module tb_pairdot_engine;

  localparam longint SAT_MAX = 64'sd549755813887;
  localparam longint SAT_MIN = -64'sd549755813888;
  localparam int MAX_PAIRS = 1024;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startPulse = 1'b0;
  logic [15:0] pairCount = '0;
  logic        extMode = 1'b0;
  logic [31:0] coefWord = '0;
  logic [31:0] dataWord = '0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        done;
  logic [15:0] resultHalf;
  logic [39:0] resultWide;

  logic [31:0] cw [MAX_PAIRS];
  logic [31:0] dw [MAX_PAIRS];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pairdot_engine dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .pairCount(pairCount),
    .extMode(extMode), .coefWord(coefWord), .dataWord(dataWord),
    .inValid(inValid), .inReady(inReady), .done(done),
    .resultHalf(resultHalf), .resultWide(resultWide)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic longint clamp(input longint v);
    if (v > SAT_MAX) return SAT_MAX;
    if (v < SAT_MIN) return SAT_MIN;
    return v;
  endfunction

  function automatic logic [39:0] model(input int n, input bit ext);
    longint evL = 0, odL = 0, s;
    int ev32 = 0, od32 = 0, s32;
    int p0, p1;
    for (int i = 0; i < n; i++) begin
      p0 = int'($signed(cw[i][15:0])) * int'($signed(dw[i][15:0]));
      p1 = int'($signed(cw[i][31:16])) * int'($signed(dw[i][31:16]));
      if (ext) begin
        evL = clamp(evL + longint'(p0));
        odL = clamp(odL + longint'(p1));
      end else begin
        ev32 = ev32 + p0;
        od32 = od32 + p1;
      end
    end
    if (ext) s = clamp(evL + odL);
    else begin
      s32 = ev32 + od32;
      s = longint'(s32);
    end
    return s[39:0];
  endfunction

  task automatic runOp(input int n, input bit ext, input int gapPct,
                       input bit poke, input string req);
    logic [39:0] exp;
    int idx = 0;
    int guard = 0;
    exp = model(n, ext);
    @(negedge clk);
    startPulse = 1'b1;
    pairCount = 16'(n);
    extMode = ext;
    @(negedge clk);
    startPulse = 1'b0;
    extMode = ~ext;
    pairCount = 16'(n + 7);
    while (idx < n && guard < 20000) begin
      guard++;
      if (poke && idx == n / 2) begin
        startPulse = 1'b1;
        pairCount = 16'd3;
        extMode = ~ext;
      end
      if (int'($urandom_range(99)) < gapPct) begin
        inValid = 1'b0;
        coefWord = $urandom;
        dataWord = $urandom;
      end else begin
        inValid = 1'b1;
        coefWord = cw[idx];
        dataWord = dw[idx];
      end
      if (inValid && inReady) idx++;
      @(negedge clk);
      startPulse = 1'b0;
    end
    inValid = 1'b1;
    coefWord = 32'h7fff7fff;
    dataWord = 32'h7fff7fff;
    chk(!inReady && !done, "R7 ready low after last pair", {62'd0, inReady, done}, 64'd0);
    @(negedge clk);
    chk(!inReady && !done, "R8 no done one edge after last pair", {62'd0, inReady, done}, 64'd0);
    @(negedge clk);
    chk(done === 1'b1, "R8 done two edges after last pair", {63'd0, done}, 64'd1);
    chk(!inReady, "R7 ready low with done", {63'd0, inReady}, 64'd0);
    chk(resultWide === exp, req, {24'd0, resultWide}, {24'd0, exp});
    chk(resultHalf === exp[15:0], "R5 halfword result", {48'd0, resultHalf}, {48'd0, exp[15:0]});
    inValid = 1'b0;
    @(negedge clk);
    chk(!done, "R8 done single cycle", {63'd0, done}, 64'd0);
    chk(resultWide === exp, "R5 result held", {24'd0, resultWide}, {24'd0, exp});
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!inReady && !done && resultWide == '0, "R1 reset state",
        {23'd0, inReady, done, resultWide}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!inReady && !done && resultWide == '0, "R1 idle after reset",
        {23'd0, inReady, done, resultWide}, 64'd0);

    // directed: lanes and signs distinguishable
    cw[0] = 32'hfffd_0002; dw[0] = 32'h0005_0007;   // 2*7 + (-3)*5 = -1
    cw[1] = 32'h0010_8000; dw[1] = 32'h0003_0001;   // -32768 + 48
    runOp(2, 1'b0, 0, 1'b0, "R2 directed lane sum");
    runOp(2, 1'b1, 0, 1'b0, "R4 directed lane sum extended");

    // zero-length run
    runOp(0, 1'b0, 0, 1'b0, "R7 zero pairs gives zero");

    // random runs with gaps, both modes, back to back
    for (int r = 0; r < 8; r++) begin
      int n;
      n = 1 + int'($urandom_range(39));
      for (int i = 0; i < n; i++) begin cw[i] = $urandom; dw[i] = $urandom; end
      runOp(n, r[0], 30, 1'b0, r[0] ? "R4 random extended" : "R2 random wrap mode");
    end

    // positive overflow: most negative squared everywhere
    for (int i = 0; i < 600; i++) begin cw[i] = 32'h80008000; dw[i] = 32'h80008000; end
    runOp(600, 1'b1, 0, 1'b0, "R4 positive saturation");
    runOp(600, 1'b0, 0, 1'b0, "R3 wrap on overflow");

    // negative saturation, then recovery inside one accumulator only
    for (int i = 0; i < 600; i++) begin cw[i] = 32'h80000001; dw[i] = 32'h7fff7fff; end
    for (int i = 600; i < 620; i++) begin cw[i] = 32'h00007fff; dw[i] = 32'h00007fff; end
    runOp(620, 1'b1, 10, 1'b0, "R4 negative saturation per step");
    runOp(620, 1'b0, 10, 1'b0, "R3 wrap negative");

    // clear between runs: small run right after the large one
    cw[0] = 32'h0001_0001; dw[0] = 32'h0001_0002;
    runOp(1, 1'b1, 0, 1'b0, "R6 accumulators cleared at start");

    // start pulse during a run is ignored
    for (int i = 0; i < 12; i++) begin cw[i] = $urandom; dw[i] = $urandom; end
    runOp(12, 1'b0, 20, 1'b1, "R9 start during run ignored");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule